// File: doc/BRIEF.md
# Serial NOR Flash Command Front-End

This block sits behind the byte-level serial interface of an emulated serial NOR flash and decides what each finished transaction does. Once the last byte of a transaction has moved, the interface presents the opcode, the three address bytes, the count of bytes the host sent and the count of bytes the host will clock back. It presents these for a single cycle with `txn_valid` high. One cycle later the block reports a result code. It has also updated its status register and holds the reply that the interface reads byte by byte through `rd_idx` / `rd_data`.

Two programmable opcode lists filter commands before any decoding takes place. An opcode on the reject list is refused as invalid. An opcode on the ignore list is acknowledged as ignored and has no effect. The reject list wins when an opcode sits on both lists. The block keeps the status register. This covers the write-enable latch, which clears after any other accepted command, and the auto-address-increment (AAI) mode bit, which admits only a small set of opcodes while it is set. The block also answers the identification commands. Array program, erase and read, and the parameter-table reads, belong to neighbouring blocks.

Top module: `nfc_front`

## Requirements
- R1: After reset, `status` equals the parameter `RESET_STATUS` (default 0x00) and `res_valid` is 0.
- R2: A transaction with `txn_cmd_len` = 0 reports result code 3 (error) and leaves the status register unchanged.
- R3: An opcode that matches an enabled reject-list entry reports result code 2 (invalid opcode), even when it is also on the ignore list, and leaves the status register unchanged.
- R4: An opcode that matches an enabled ignore-list entry and no reject-list entry reports result code 1 (ignored) and changes nothing. This includes the write-enable latch.
- R5: While status bit 6 (AAI) is set, only opcodes 0xAD, 0x04 and 0x05 are executed. Any other opcode reports result code 1 and leaves the status register unchanged.
- R6: Opcodes 0x06 and 0x50 set status bit 1 (WEL). Every other command that completes with result code 0 leaves WEL at 0.
- R7: Opcode 0x01 with at least 2 command bytes, sent while WEL = 1, loads the status register from the byte after the opcode (`txn_addr[23:16]`) with bit 0 (busy) and WEL forced to 0. When WEL = 0 the status register stays unchanged. Both cases report result code 0.
- R8: Opcode 0x05 returns, at every byte index, the status value held before the command.
- R9: Opcode 0x90 with at least 4 command bytes returns, at byte index i, `DEV_ID` (default 0x4A) when `(txn_addr + txn_cmd_len - 4 + i)` is odd and `MFR_ID` (default 0xBF) when it is even. With fewer than 4 command bytes every byte reads 0xFF.
- R10: Opcode 0x9F returns `JEDEC_MFR`, `JEDEC_TYPE` and `JEDEC_CAP` (defaults 0xC2, 0x20, 0x17) at indices 0, 1 and 2, and 0xFF at higher indices.
- R11: An unrecognized opcode reports result code 0 and reads 0xFF. Any command with a non-zero result code also reads 0xFF.
- R12: Opcode 0xAB with at least 4 command bytes returns `SIG_ID` (default 0x16) at every index. With fewer than 4 command bytes it reads 0xFF.
- R13: Opcode 0xAD sets status bit 6 (AAI), and opcode 0x04 clears it.
- R14: `res_valid` is high for exactly the cycle after a `txn_valid` cycle. Any byte index at or above `txn_rsp_len` reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_valid | input | 1 | One-cycle strobe: transaction fields are valid |
| txn_op | input | 8 | First command byte (opcode) |
| txn_addr | input | 24 | Command bytes 1..3, byte 1 in bits 23:16 |
| txn_cmd_len | input | LEN_W | Number of command bytes sent |
| txn_rsp_len | input | LEN_W | Number of reply bytes requested |
| lst_we | input | 1 | Write strobe for one opcode-list entry |
| lst_sel | input | 1 | List select: 0 reject list, 1 ignore list |
| lst_idx | input | $clog2(LIST_DEPTH) | Entry index |
| lst_op | input | 8 | Opcode stored in the entry |
| lst_on | input | 1 | Entry enable |
| rd_idx | input | LEN_W | Reply byte index |
| rd_data | output | 8 | Reply byte at `rd_idx` |
| res_valid | output | 1 | Result strobe |
| res_code | output | 2 | 0 ok, 1 ignored, 2 invalid opcode, 3 error |
| status | output | 8 | Current status register |

## Verification
The AAI gate is swept across every opcode except the three it admits. Each of these must be refused while the status register holds still, and this separates correct gating from a gate that leaks or that blocks too much. The ID-pair reply is swept over both address parities, four command lengths and four byte indices. This shows whether the start offset takes the address, the length and the byte index into account, or leaves one of them out. The list tests place the same opcode on both lists and then switch the entries off one at a time, which exposes the order of precedence. Single cases cover zero length, a status write without the latch, and reply indices past the requested count.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

    typedef enum logic [1:0] {
        RES_OK    = 2'd0,
        RES_IGN   = 2'd1,
        RES_BADOP = 2'd2,
        RES_ERR   = 2'd3
    } res_e;

    typedef enum logic [2:0] {
        RSP_FILL  = 3'd0,
        RSP_STAT  = 3'd1,
        RSP_PAIR  = 3'd2,
        RSP_JEDEC = 3'd3,
        RSP_SIG   = 3'd4
    } rsp_e;

    localparam logic [7:0] OP_SR_WRITE  = 8'h01;
    localparam logic [7:0] OP_WR_OFF    = 8'h04;
    localparam logic [7:0] OP_SR_READ   = 8'h05;
    localparam logic [7:0] OP_WR_ON     = 8'h06;
    localparam logic [7:0] OP_SR_UNLOCK = 8'h50;
    localparam logic [7:0] OP_ID_PAIR   = 8'h90;
    localparam logic [7:0] OP_ID_JEDEC  = 8'h9F;
    localparam logic [7:0] OP_ID_SIG    = 8'hAB;
    localparam logic [7:0] OP_AAI_WORD  = 8'hAD;

    localparam int SB_BUSY = 0;
    localparam int SB_WEL  = 1;
    localparam int SB_AAI  = 6;

endpackage

// File: rtl/nfc_op_list.sv
module nfc_op_list #(
    parameter int DEPTH = 8,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [7:0]    wr_op,
    input  logic          wr_on,
    input  logic [7:0]    probe_op,
    output logic          hit
);
    logic [7:0]       ent_op_q [DEPTH];
    logic [DEPTH-1:0] ent_on_q;
    logic [DEPTH-1:0] match;

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_op_q[g] <= 8'h00;
                ent_on_q[g] <= 1'b0;
            end else if (wr_en && wr_idx == IW'(g)) begin
                ent_op_q[g] <= wr_op;
                ent_on_q[g] <= wr_on;
            end
        end
        assign match[g] = ent_on_q[g] && (ent_op_q[g] == probe_op);
    end

    assign hit = |match;
endmodule

// File: rtl/nfc_reply.sv
module nfc_reply
    import nfc_pkg::*;
#(
    parameter int         LEN_W      = 9,
    parameter logic [7:0] MFR_ID     = 8'hBF,
    parameter logic [7:0] DEV_ID     = 8'h4A,
    parameter logic [7:0] JEDEC_MFR  = 8'hC2,
    parameter logic [7:0] JEDEC_TYPE = 8'h20,
    parameter logic [7:0] JEDEC_CAP  = 8'h17,
    parameter logic [7:0] SIG_ID     = 8'h16
) (
    input  rsp_e             kind,
    input  logic             par,
    input  logic [7:0]       snap,
    input  logic [LEN_W-1:0] count,
    input  logic [LEN_W-1:0] idx,
    output logic [7:0]       rd_o
);
    always_comb begin
        rd_o = 8'hFF;
        if (idx < count) begin
            case (kind)
                RSP_STAT: rd_o = snap;
                RSP_PAIR: rd_o = (par ^ idx[0]) ? DEV_ID : MFR_ID;
                RSP_JEDEC: begin
                    if (idx == LEN_W'(0))      rd_o = JEDEC_MFR;
                    else if (idx == LEN_W'(1)) rd_o = JEDEC_TYPE;
                    else if (idx == LEN_W'(2)) rd_o = JEDEC_CAP;
                end
                RSP_SIG:  rd_o = SIG_ID;
                default:  rd_o = 8'hFF;
            endcase
        end
    end
endmodule

// File: rtl/nfc_front.sv
module nfc_front
    import nfc_pkg::*;
#(
    parameter int         LEN_W        = 9,
    parameter int         LIST_DEPTH   = 8,
    parameter logic [7:0] RESET_STATUS = 8'h00,
    parameter logic [7:0] MFR_ID       = 8'hBF,
    parameter logic [7:0] DEV_ID       = 8'h4A,
    parameter logic [7:0] JEDEC_MFR    = 8'hC2,
    parameter logic [7:0] JEDEC_TYPE   = 8'h20,
    parameter logic [7:0] JEDEC_CAP    = 8'h17,
    parameter logic [7:0] SIG_ID       = 8'h16,
    localparam int LIST_IW = (LIST_DEPTH > 1) ? $clog2(LIST_DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               txn_valid,
    input  logic [7:0]         txn_op,
    input  logic [23:0]        txn_addr,
    input  logic [LEN_W-1:0]   txn_cmd_len,
    input  logic [LEN_W-1:0]   txn_rsp_len,
    input  logic               lst_we,
    input  logic               lst_sel,
    input  logic [LIST_IW-1:0] lst_idx,
    input  logic [7:0]         lst_op,
    input  logic               lst_on,
    input  logic [LEN_W-1:0]   rd_idx,
    output logic [7:0]         rd_data,
    output logic               res_valid,
    output logic [1:0]         res_code,
    output logic [7:0]         status
);
    typedef struct packed {
        logic [7:0]       sr;
        logic             vld;
        res_e             res;
        rsp_e             kind;
        logic             par;
        logic [7:0]       snap;
        logic [LEN_W-1:0] cnt;
        logic [7:0]       op;
    } st_t;

    st_t  st_d, st_q;
    logic rej_hit, ign_hit, aai_ok;
    logic [7:0] sr_n;

    nfc_op_list #(.DEPTH(LIST_DEPTH)) u_reject (
        .clk(clk), .rst_n(rst_n),
        .wr_en(lst_we && !lst_sel), .wr_idx(lst_idx), .wr_op(lst_op), .wr_on(lst_on),
        .probe_op(txn_op), .hit(rej_hit)
    );

    nfc_op_list #(.DEPTH(LIST_DEPTH)) u_ignore (
        .clk(clk), .rst_n(rst_n),
        .wr_en(lst_we && lst_sel), .wr_idx(lst_idx), .wr_op(lst_op), .wr_on(lst_on),
        .probe_op(txn_op), .hit(ign_hit)
    );

    assign aai_ok = (txn_op == OP_AAI_WORD) || (txn_op == OP_WR_OFF) || (txn_op == OP_SR_READ);

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        sr_n     = st_q.sr;
        if (txn_valid) begin
            st_d.vld  = 1'b1;
            st_d.kind = RSP_FILL;
            st_d.cnt  = txn_rsp_len;
            st_d.op   = txn_op;
            st_d.par  = txn_addr[0] ^ txn_cmd_len[0];
            st_d.snap = st_q.sr;
            if (txn_cmd_len == '0) begin
                st_d.res = RES_ERR;
            end else if (rej_hit) begin
                st_d.res = RES_BADOP;
            end else if (ign_hit) begin
                st_d.res = RES_IGN;
            end else if (st_q.sr[SB_AAI] && !aai_ok) begin
                st_d.res = RES_IGN;
            end else begin
                st_d.res = RES_OK;
                case (txn_op)
                    OP_WR_ON, OP_SR_UNLOCK: sr_n[SB_WEL] = 1'b1;
                    OP_SR_WRITE: begin
                        if (st_q.sr[SB_WEL] && txn_cmd_len >= LEN_W'(2)) begin
                            sr_n = txn_addr[23:16];
                            sr_n[SB_BUSY] = 1'b0;
                        end
                    end
                    OP_SR_READ:  st_d.kind = RSP_STAT;
                    OP_ID_PAIR:  if (txn_cmd_len >= LEN_W'(4)) st_d.kind = RSP_PAIR;
                    OP_ID_JEDEC: st_d.kind = RSP_JEDEC;
                    OP_ID_SIG:   if (txn_cmd_len >= LEN_W'(4)) st_d.kind = RSP_SIG;
                    OP_AAI_WORD: sr_n[SB_AAI] = 1'b1;
                    OP_WR_OFF:   sr_n[SB_AAI] = 1'b0;
                    default: ;
                endcase
                if (txn_op != OP_WR_ON && txn_op != OP_SR_UNLOCK) sr_n[SB_WEL] = 1'b0;
                st_d.sr = sr_n;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.sr   <= RESET_STATUS;
            st_q.res  <= RES_OK;
            st_q.kind <= RSP_FILL;
        end else begin
            st_q <= st_d;
        end
    end

    nfc_reply #(
        .LEN_W(LEN_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID), .JEDEC_MFR(JEDEC_MFR),
        .JEDEC_TYPE(JEDEC_TYPE), .JEDEC_CAP(JEDEC_CAP), .SIG_ID(SIG_ID)
    ) u_reply (
        .kind(st_q.kind), .par(st_q.par), .snap(st_q.snap), .count(st_q.cnt),
        .idx(rd_idx), .rd_o(rd_data)
    );

    assign res_valid = st_q.vld;
    assign res_code  = st_q.res;
    assign status    = st_q.sr;

    assert_zero_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && txn_cmd_len == '0 |=> res_valid && res_code == RES_ERR && $stable(status));

    assert_reject_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && txn_cmd_len != '0 && rej_hit |=> res_code == RES_BADOP && $stable(status));

    assert_aai_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && txn_cmd_len != '0 && !rej_hit && !ign_hit && status[SB_AAI] && !aai_ok
        |=> res_code == RES_IGN && $stable(status));

    assert_wel_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_code == RES_OK && st_q.op != OP_WR_ON && st_q.op != OP_SR_UNLOCK
        |-> !status[SB_WEL]);

    assert_no_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && txn_cmd_len >= LEN_W'(2) && txn_op == OP_SR_WRITE && status[SB_WEL]
        && !rej_hit && !ign_hit && !status[SB_AAI] |=> !status[SB_BUSY]);

    assert_strobe_R14: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(txn_valid));
endmodule

// File: tb/nfc_front_tb_top.sv
`timescale 1ns/100ps
module nfc_front_tb_top;
    localparam int LEN_W = 9;
    localparam logic [7:0] MFR = 8'hBF, DEV = 8'h4A;
    localparam logic [7:0] JM = 8'hC2, JT = 8'h20, JC = 8'h17, SIG = 8'h16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic txn_valid = 1'b0;
    logic [7:0] txn_op = 8'h00;
    logic [23:0] txn_addr = '0;
    logic [LEN_W-1:0] txn_cmd_len = '0, txn_rsp_len = '0, rd_idx = '0;
    logic lst_we = 1'b0, lst_sel = 1'b0, lst_on = 1'b0;
    logic [2:0] lst_idx = '0;
    logic [7:0] lst_op = '0;
    logic [7:0] rd_data, status;
    logic res_valid;
    logic [1:0] res_code;

    int nchk = 0, nerr = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nfc_front dut_i (
        .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_op(txn_op), .txn_addr(txn_addr),
        .txn_cmd_len(txn_cmd_len), .txn_rsp_len(txn_rsp_len), .lst_we(lst_we), .lst_sel(lst_sel),
        .lst_idx(lst_idx), .lst_op(lst_op), .lst_on(lst_on), .rd_idx(rd_idx), .rd_data(rd_data),
        .res_valid(res_valid), .res_code(res_code), .status(status)
    );

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] op, input logic [23:0] a, input int clen, input int rlen);
        @(negedge clk);
        txn_valid = 1'b1; txn_op = op; txn_addr = a;
        txn_cmd_len = LEN_W'(clen); txn_rsp_len = LEN_W'(rlen);
        @(negedge clk);
        txn_valid = 1'b0;
    endtask

    task automatic rdb(input int idx, output logic [7:0] v);
        rd_idx = LEN_W'(idx);
        #0.5;
        v = rd_data;
    endtask

    task automatic prog(input logic sel, input int idx, input logic [7:0] op, input logic on);
        @(negedge clk);
        lst_we = 1'b1; lst_sel = sel; lst_idx = 3'(idx); lst_op = op; lst_on = on;
        @(negedge clk);
        lst_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        check("R1 reset status", status, 8'h00);
        check("R1 reset res_valid", res_valid, 0);
        rst_n = 1'b1;

        // R2: zero length
        send(8'h06, 0, 0, 1);
        check("R14 strobe", res_valid, 1);
        check("R2 code", res_code, 3);
        check("R2 status", status, 8'h00);
        @(negedge clk);
        check("R14 strobe drops", res_valid, 0);

        // R6 / R8
        send(8'h06, 0, 1, 0);
        check("R6 wel set", status, 8'h02);
        send(8'h05, 0, 1, 3);
        check("R8 code", res_code, 0);
        for (int i = 0; i < 3; i++) begin rdb(i, v); check("R8 byte", v, 8'h02); end
        rdb(3, v); check("R14 beyond count", v, 8'hFF);
        check("R6 wel cleared by read", status, 8'h00);

        // R7 refused without WEL
        send(8'h01, 24'hFF0000, 2, 0);
        check("R7 refused code", res_code, 0);
        check("R7 refused status", status, 8'h00);
        // R7 accepted
        send(8'h50, 0, 1, 0);
        check("R6 unlock sets wel", status, 8'h02);
        send(8'h01, 24'hFF0000, 2, 0);
        check("R7 loaded", status, 8'hFC);

        // R5 sweep in AAI mode
        for (int op = 0; op < 256; op++) begin
            if (op == 8'hAD || op == 8'h04 || op == 8'h05) continue;
            send(8'(op), 0, 4, 2);
            check("R5 gated code", res_code, 1);
            check("R5 gated status", status, 8'hFC);
            rdb(0, v); check("R11 non-ok reads FF", v, 8'hFF);
        end
        send(8'h05, 0, 1, 1);
        check("R5 read allowed", res_code, 0);
        rdb(0, v); check("R8 aai read", v, 8'hFC);
        send(8'h04, 0, 1, 0);
        check("R13 aai off", status, 8'hBC);
        send(8'hAD, 0, 6, 0);
        check("R13 aai on", status, 8'hFC);
        send(8'h04, 0, 1, 0);
        check("R13 aai off again", status, 8'hBC);
        send(8'h06, 0, 1, 0);
        send(8'h01, 24'h000000, 2, 0);
        check("R7 clear", status, 8'h00);

        // R9 pair sweep
        for (int a0 = 0; a0 < 2; a0++)
            for (int len = 4; len < 8; len++) begin
                send(8'h90, {8'h00, 8'h01, 7'h00, 1'(a0)}, len, 4);
                for (int i = 0; i < 4; i++) begin
                    rdb(i, v);
                    check("R9 pair", v, ((a0 + len - 4 + i) % 2) ? DEV : MFR);
                end
            end
        send(8'h90, 0, 3, 2);
        rdb(0, v); check("R9 short", v, 8'hFF);

        // R10
        send(8'h9F, 0, 1, 5);
        rdb(0, v); check("R10 b0", v, JM);
        rdb(1, v); check("R10 b1", v, JT);
        rdb(2, v); check("R10 b2", v, JC);
        rdb(3, v); check("R10 b3", v, 8'hFF);
        // R12
        send(8'hAB, 0, 4, 3);
        for (int i = 0; i < 3; i++) begin rdb(i, v); check("R12 sig", v, SIG); end
        send(8'hAB, 0, 3, 3);
        rdb(0, v); check("R12 short", v, 8'hFF);
        // R11
        send(8'h3C, 0, 4, 2);
        check("R11 code", res_code, 0);
        rdb(0, v); check("R11 byte", v, 8'hFF);

        // R3 / R4 lists
        send(8'h50, 0, 1, 0);
        prog(1'b0, 0, 8'h06, 1'b1);
        prog(1'b1, 0, 8'h06, 1'b1);
        prog(1'b1, 1, 8'h05, 1'b1);
        send(8'h06, 0, 1, 1);
        check("R3 reject wins", res_code, 2);
        check("R3 status", status, 8'h02);
        rdb(0, v); check("R11 reject reads FF", v, 8'hFF);
        send(8'h05, 0, 1, 1);
        check("R4 ignored code", res_code, 1);
        check("R4 wel kept", status, 8'h02);
        rdb(0, v); check("R4 ignored reads FF", v, 8'hFF);
        prog(1'b0, 0, 8'h06, 1'b0);
        send(8'h06, 0, 1, 0);
        check("R4 ignore after reject off", res_code, 1);
        prog(1'b1, 0, 8'h06, 1'b0);
        send(8'h06, 0, 1, 0);
        check("R6 executes after lists off", res_code, 0);
        send(8'h9F, 0, 1, 1);
        check("R6 wel cleared", status, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule